// File: doc/BRIEF.md
# Serial Port Status Flags with Armed Clearing

This block holds the status and data-register handshake of a byte-wide serial peripheral port, as seen from a simple register bus. It keeps three flags: a receive-complete flag, a transmit-empty flag and a mode-fault flag. None of them can be cleared by a single access. Software must first read the status register while the flag is set. That read arms the flag. The matching follow-up access then clears it: a data-register read, a data-register write, or a control-register write.

The serial shifter sits outside this block and appears only as strobes. A received-byte strobe loads the data register. A take strobe tells the block that the shifter has consumed the pending transmit byte. A mode fault is raised when the slave-select input falls while the port is a master and fault detection is enabled. A data-register write that was not armed is dropped without any effect.

The bus uses addresses 1 (status), 2 (data) and 0 (control 1). A read returns its value on `bus_rdata` from the clock edge that accepts the read.

Top module: `spi_stat_flags`

## Requirements
- R1: The status byte places receive-complete at bit 7, transmit-empty at bit 5 and mode-fault at bit 4. Bits 6 and 3..0 always read 0.
- R2: After reset the status byte reads 0x20, the data register reads 0x00 and `tx_valid` is 0.
- R3: A write to the status address changes no flag.
- R4: A `rx_valid` strobe loads `rx_byte` into the data register and sets receive-complete.
- R5: Receive-complete clears only on a data read that follows a status read which saw it set. A data read without that arming returns the data and leaves the flag set.
- R6: A data write that follows a status read which saw transmit-empty set clears transmit-empty. The same write presents the written byte on `tx_data` with `tx_valid` high.
- R7: A data write that is not armed leaves `tx_data`, `tx_valid` and transmit-empty unchanged.
- R8: Mode-fault sets when `ss_n` falls while `is_master` and `fault_en` are both 1. A fall of `ss_n` with either of them at 0 does not set it.
- R9: Mode-fault clears only on a control write that follows a status read which saw it set. An unarmed control write leaves it set.
- R10: An arm is used up by its clearing access. A second follow-up access without a new status read clears nothing.
- R11: A `tx_take` strobe while a byte is pending drops `tx_valid` and sets transmit-empty again.
- R12: When a set event and the armed clearing access fall in the same cycle, the flag stays set.
- R13: `bus_rdata` carries the read value from the clock edge that accepts the read and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address (0 control 1, 1 status, 2 data) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Shifter has a received byte |
| rx_byte | input | 8 | Received byte |
| tx_take | input | 1 | Shifter consumes the pending transmit byte |
| tx_valid | output | 1 | A transmit byte is pending |
| tx_data | output | 8 | Pending transmit byte |
| ss_n | input | 1 | Slave-select pin level |
| is_master | input | 1 | Port operates as master |
| fault_en | input | 1 | Mode-fault detection enable |

## Verification
Several rules are checked by assertions on every cycle. Reserved status bits must read zero. Receive-complete may fall only after a data read, and mode-fault only after a control write. A receive strobe must leave its flag set even when a clear is requested in the same cycle. An arm must be gone after its use. `tx_valid` must always be the inverse of transmit-empty, and `tx_data` may move only on an accepted write. The bench's scenarios cover the rules that depend on access history, which no single-cycle property can see: whether a data access was armed by an earlier status read, how the arm is used up, how the three qualifying inputs combine at a falling `ss_n`, and the exact values read back.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int NFLAG  = 3;
  localparam int FI_RX  = 0;
  localparam int FI_TX  = 1;
  localparam int FI_MF  = 2;
  localparam int BIT_RX = 7;
  localparam int BIT_TX = 5;
  localparam int BIT_MF = 4;
endpackage

// File: rtl/spi_flag_cell.sv
// One status flag with its own arm bit: armed by a status read, cleared by the follow-up access.
module spi_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic snap,
  input  logic clr_acc,
  output logic flag,
  output logic fire
);
  logic arm;

  assign fire = clr_acc & arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= RST_VAL;
      arm  <= 1'b0;
    end else begin
      if (snap)
        arm <= flag;
      else if (fire)
        arm <= 1'b0;
      // set wins over a simultaneous clear (R12)
      if (set_ev)
        flag <= 1'b1;
      else if (fire)
        flag <= 1'b0;
    end
  end

  // R10: an arm does not survive its clearing access
  a_r10_arm_used: assert property (@(posedge clk) disable iff (rst)
    (fire && !snap) |=> !arm);
  // R12: a set event always leaves the flag high
  a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> flag);
endmodule

// File: rtl/spi_data_regs.sv
// Receive data register and transmit holding register.
module spi_data_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] rx_data,
  input  logic          tx_accept,
  input  logic [DW-1:0] wdata,
  input  logic          tx_take,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else begin
      if (rx_valid)
        rx_data <= rx_byte;
      if (tx_accept) begin
        tx_data  <= wdata;
        tx_valid <= 1'b1;
      end else if (tx_take) begin
        tx_valid <= 1'b0;
      end
    end
  end

  // R7: the transmit byte moves only on an accepted write
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_data) |-> $past(tx_accept));
endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
  import spi_flag_pkg::*;
#(
  parameter int             DW        = 8,
  parameter int             ADDR_W    = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 3'd0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 3'd1,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 3'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_byte,
  input  logic              tx_take,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_data,
  input  logic              ss_n,
  input  logic              is_master,
  input  logic              fault_en
);
  logic stat_rd, data_rd, data_wr, ctrl_wr;
  logic ss_q, fault_ev;
  logic [NFLAG-1:0] set_v, clr_v, flag_v, fire_v;
  logic [DW-1:0] rx_data, stat_word;

  assign stat_rd = bus_en & ~bus_we & (bus_addr == STAT_ADDR);
  assign data_rd = bus_en & ~bus_we & (bus_addr == DATA_ADDR);
  assign data_wr = bus_en &  bus_we & (bus_addr == DATA_ADDR);
  assign ctrl_wr = bus_en &  bus_we & (bus_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) ss_q <= 1'b1;
    else     ss_q <= ss_n;
  end
  assign fault_ev = ss_q & ~ss_n & is_master & fault_en;

  assign set_v[FI_RX] = rx_valid;
  assign set_v[FI_TX] = tx_take & tx_valid;
  assign set_v[FI_MF] = fault_ev;
  assign clr_v[FI_RX] = data_rd;
  assign clr_v[FI_TX] = data_wr;
  assign clr_v[FI_MF] = ctrl_wr;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    spi_flag_cell #(.RST_VAL(i == FI_TX)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .set_ev  (set_v[i]),
      .snap    (stat_rd),
      .clr_acc (clr_v[i]),
      .flag    (flag_v[i]),
      .fire    (fire_v[i])
    );
  end

  spi_data_regs #(.DW(DW)) u_data (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_data   (rx_data),
    .tx_accept (fire_v[FI_TX]),
    .wdata     (bus_wdata),
    .tx_take   (tx_take),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid)
  );

  always_comb begin
    stat_word         = '0;
    stat_word[BIT_RX] = flag_v[FI_RX];
    stat_word[BIT_TX] = flag_v[FI_TX];
    stat_word[BIT_MF] = flag_v[FI_MF];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_en && !bus_we) begin
      if (bus_addr == STAT_ADDR)      bus_rdata <= stat_word;
      else if (bus_addr == DATA_ADDR) bus_rdata <= rx_data;
      else                            bus_rdata <= '0;
    end
  end

  // R1: reserved status bits read back as zero
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    $past(stat_rd) |-> ((bus_rdata & 8'h4F) == 8'h00));
  // R5: receive-complete falls only after a data read
  a_r5_rx_clear_src: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_v[FI_RX]) |-> $past(data_rd));
  // R9: mode-fault falls only after a control write
  a_r9_mf_clear_src: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_v[FI_MF]) |-> $past(ctrl_wr));
  // R8: a qualified falling slave-select raises mode-fault
  a_r8_mf_set: assert property (@(posedge clk) disable iff (rst)
    fault_ev |=> flag_v[FI_MF]);
  // R6 / R11: pending byte and transmit-empty stay complementary
  a_r6_tx_consistent: assert property (@(posedge clk) disable iff (rst)
    tx_valid == !flag_v[FI_TX]);
endmodule

// File: tb/tb_spi_stat_flags.sv
module tb_spi_stat_flags;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_en, bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       tx_take, tx_valid;
  logic [7:0] tx_data;
  logic       ss_n, is_master, fault_en;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  spi_stat_flags dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_take(tx_take), .tx_valid(tx_valid), .tx_data(tx_data),
    .ss_n(ss_n), .is_master(is_master), .fault_en(fault_en)
  );

  localparam logic [2:0] A_CTL = 3'd0, A_ST = 3'd1, A_DAT = 3'd2;
  // entry: {op[2], addr[3], data[8], expect[8], check[1], req[4]}
  // op 0 read, 1 write, 2 receive strobe, 3 transmit take
  localparam int NV = 20;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, A_ST,  8'h00, 8'h20, 1'b1, 4'd2},   // R2 R1 reset status
    {2'd1, A_ST,  8'hFF, 8'h00, 1'b0, 4'd3},   // R3 status write
    {2'd0, A_ST,  8'h00, 8'h20, 1'b1, 4'd3},   // R3 unchanged
    {2'd0, A_DAT, 8'h00, 8'h00, 1'b1, 4'd2},   // R2 data reset
    {2'd2, A_ST,  8'hA5, 8'h00, 1'b0, 4'd4},   // R4 receive
    {2'd0, A_ST,  8'h00, 8'hA0, 1'b1, 4'd4},   // R4 flag set, arms
    {2'd0, A_DAT, 8'h00, 8'hA5, 1'b1, 4'd13},  // R13 R5 armed read
    {2'd0, A_ST,  8'h00, 8'h20, 1'b1, 4'd5},   // R5 cleared
    {2'd2, A_ST,  8'h3C, 8'h00, 1'b0, 4'd4},
    {2'd0, A_DAT, 8'h00, 8'h3C, 1'b1, 4'd5},   // R5 unarmed read
    {2'd0, A_ST,  8'h00, 8'hA0, 1'b1, 4'd5},   // R5 still set
    {2'd0, A_DAT, 8'h00, 8'h3C, 1'b1, 4'd5},   // armed, clears
    {2'd2, A_ST,  8'h11, 8'h00, 1'b0, 4'd10},
    {2'd0, A_DAT, 8'h00, 8'h11, 1'b1, 4'd10},  // R10 arm used up
    {2'd0, A_ST,  8'h00, 8'hA0, 1'b1, 4'd10},  // R10 flag kept
    {2'd1, A_DAT, 8'h77, 8'h00, 1'b0, 4'd6},   // R6 armed write
    {2'd1, A_DAT, 8'h99, 8'h00, 1'b0, 4'd7},   // R7 unarmed write
    {2'd0, A_ST,  8'h00, 8'h80, 1'b1, 4'd6},   // R6 tx-empty cleared
    {2'd3, A_ST,  8'h00, 8'h00, 1'b0, 4'd11},  // R11 take
    {2'd0, A_ST,  8'h00, 8'hA0, 1'b1, 4'd11}   // R11 tx-empty back
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_en = 0; bus_we = 0; rx_valid = 0; tx_take = 0;
  endtask

  task automatic acc(input logic we, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] mask,
                        input logic [7:0] exp, input string req);
    acc(1'b0, a, 8'h00);
    chk(req, bus_rdata & mask, exp);
  endtask

  task automatic ss_fall(input logic m, input logic e);
    @(negedge clk);
    is_master = m; fault_en = e; ss_n = 1'b0;
    @(negedge clk);
    ss_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle();
    bus_addr = 0; bus_wdata = 0; rx_byte = 0;
    ss_n = 1; is_master = 0; fault_en = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R2 tx_valid", {7'd0, tx_valid}, 8'h00);
    chk("R2 rdata", bus_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      @(negedge clk);
      case (v[25:24])
        2'd0: begin bus_en = 1; bus_we = 0; bus_addr = v[23:21]; end
        2'd1: begin bus_en = 1; bus_we = 1; bus_addr = v[23:21]; bus_wdata = v[20:13]; end
        2'd2: begin rx_valid = 1; rx_byte = v[20:13]; end
        default: tx_take = 1;
      endcase
      @(negedge clk);
      idle();
      if (v[4])
        chk($sformatf("R%0d vector %0d", v[3:0], i), bus_rdata, v[12:5]);
    end
    chk("R11 tx_valid after take", {7'd0, tx_valid}, 8'h00);
    chk("R7 tx_data kept first byte", tx_data, 8'h77);

    // R6 / R7 directed
    rd_chk(A_ST, 8'h20, 8'h20, "R6 empty before write");
    acc(1'b1, A_DAT, 8'h5A);
    chk("R6 tx_valid", {7'd0, tx_valid}, 8'h01);
    chk("R6 tx_data", tx_data, 8'h5A);
    acc(1'b1, A_DAT, 8'h66);
    chk("R7 tx_data", tx_data, 8'h5A);
    rd_chk(A_ST, 8'h20, 8'h00, "R7 tx-empty still clear");
    @(negedge clk); tx_take = 1; @(negedge clk); idle();
    chk("R11 drop", {7'd0, tx_valid}, 8'h00);

    // R8 qualification
    ss_fall(1'b0, 1'b1);
    rd_chk(A_ST, 8'h10, 8'h00, "R8 not master");
    ss_fall(1'b1, 1'b0);
    rd_chk(A_ST, 8'h10, 8'h00, "R8 detection off");
    ss_fall(1'b1, 1'b1);
    // R9 unarmed control write (last status read saw mode-fault clear)
    acc(1'b1, A_CTL, 8'h00);
    rd_chk(A_ST, 8'h10, 8'h10, "R8 R9 set and kept");
    acc(1'b1, A_CTL, 8'h00);
    rd_chk(A_ST, 8'h10, 8'h00, "R9 armed clear");

    // R12 set wins
    @(negedge clk); rx_valid = 1; rx_byte = 8'h21; @(negedge clk); idle();
    rd_chk(A_ST, 8'h80, 8'h80, "R12 armed");
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = A_DAT; rx_valid = 1; rx_byte = 8'h42;
    @(negedge clk); idle();
    chk("R12 data read value", bus_rdata, 8'h21);
    rd_chk(A_ST, 8'h80, 8'h80, "R12 flag kept");
    rd_chk(A_DAT, 8'hFF, 8'h42, "R12 new byte");
    rd_chk(A_ST, 8'h80, 8'h00, "R12 later clear");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule